// File: doc/BRIEF.md
# Pausable Serial Register Write Receiver

This block receives framed serial writes on the slave side and lands each 24-bit word in one of two destination registers, a control word or a calibration word. The serial clock, the active-low frame, the data line and the destination-select line come from an external master. All four are brought into the system clock domain through a two-stage synchronizer. A rising edge on the synchronized serial clock makes a one-cycle sample strobe, and a bit is taken only while the frame is low.

A word can be sent in pieces. The master may raise the frame partway through a word, hold it high for any time, and lower it again. The bit position is kept across the pause, so the next bit taken is the next bit of the same word. When the 24th bit arrives, the word is committed to the register that the select line chose at the first bit, and a one-cycle write strobe and a destination indicator are produced. If the select line changes while a word is partly received, the word is dropped and a protocol-error pulse is raised. An abort input also drops a partly received word.

A data-ready status flag sits beside the write path. Writes neither change it nor wait for it. The commit interface is a plain pulse and has no ready input, so a commit cannot be held back; a consumer that needs the word must take it in the strobe cycle or read the held register.

Top module: `serial_write_rx`

## Requirements
- R1: After reset, both destination registers read zero, the write strobe, the destination indicator and the error pulse are low, the data-ready flag is low, and the bit position is zero.
- R2: A word is made of exactly 24 bits taken most significant bit first. The committed value equals the bits in the order they were sent.
- R3: If the select line is low at the first bit, the word goes to the control register (destination code 0). If it is high, the word goes to the calibration register (destination code 1). The other register keeps its value.
- R4: A bit is taken only on a rising serial-clock edge while the frame is low. Serial-clock edges while the frame is high change neither the bit position nor any register.
- R5: When the frame is raised mid-word and lowered again, reception resumes at the next bit position of the same word.
- R6: Each commit gives a `wr_stb_o` pulse lasting exactly one cycle, with `wr_dest_o` showing the destination code, in the cycle the register takes its new value. Fewer than 24 bits never cause a commit.
- R7: If the synchronized select line differs from its value at the first bit while the bit position is not zero, `proto_err_o` pulses for one cycle and the partial word is dropped. The next bit taken starts a new word.
- R8: A high `abort_i` drops any partial word, and the next bit taken starts a new word.
- R9: `ready_o` is set by `conv_done_i` and cleared by `ready_clr_i`. Set wins when both are high. Write traffic and commits leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | External serial clock, idles low |
| frame_n_i | input | 1 | Active-low frame; changes only while sclk_i is low |
| sdata_i | input | 1 | Serial data, valid while sclk_i is high |
| dest_sel_i | input | 1 | Destination select: 0 control, 1 calibration |
| abort_i | input | 1 | Synchronous drop of a partial word |
| conv_done_i | input | 1 | Sets the data-ready flag |
| ready_clr_i | input | 1 | Clears the data-ready flag |
| ctrl_word_o | output | 24 | Control register contents |
| cal_word_o | output | 24 | Calibration register contents |
| wr_stb_o | output | 1 | One-cycle pulse on each commit |
| wr_dest_o | output | 1 | Destination code of the current commit |
| proto_err_o | output | 1 | One-cycle pulse when a word is dropped because the select line changed |
| ready_o | output | 1 | Data-ready status flag |

## Verification
The bench sends words with asymmetric bit patterns, so a reversed bit order or a one-bit shift gives a visibly wrong value. It routes words to both destinations and checks that the other register is left alone. Serial-clock edges sent with the frame high, followed by a full word, expose a receiver that samples outside the frame: that word would come out shifted or be committed early. A word split by a pause that contains serial-clock edges catches a design that resets or advances its bit position during the pause. A select change mid-word and an abort are each followed by a clean word, so a design that keeps stale bits commits a corrupted value. The data-ready flag is checked across a full write, which catches any coupling between the write path and the flag.

// File: rtl/serial_wr_pkg.sv
package serial_wr_pkg;
  localparam int unsigned WORD_W   = 24;
  localparam int unsigned NUM_DEST = 2;

  typedef enum logic {
    DEST_CTRL = 1'b0,
    DEST_CAL  = 1'b1
  } dest_e;
endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
  parameter int unsigned        W       = 4,
  parameter int unsigned        STAGES  = 2,
  parameter logic [W-1:0]       RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= async_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sw_edge.sv
module sw_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;

  // R4
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/sw_shift_core.sv
module sw_shift_core
  import serial_wr_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_stb_i,
  input  logic         frame_n_i,
  input  logic         data_i,
  input  logic         sel_i,
  input  logic         abort_i,
  output logic         commit_o,
  output logic [W-1:0] word_o,
  output dest_e        dest_o,
  output logic         err_o
);
  localparam int unsigned CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W-1);

  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     sh_q;
  dest_e            dest_q;
  logic             take;
  logic             sel_moved;
  logic [W-1:0]     sh_next;

  assign take      = sample_stb_i & ~frame_n_i;
  assign sel_moved = (cnt_q != '0) && (dest_e'(sel_i) != dest_q);
  assign sh_next   = {sh_q[W-2:0], data_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      dest_q   <= DEST_CTRL;
      commit_o <= 1'b0;
      word_o   <= '0;
      dest_o   <= DEST_CTRL;
      err_o    <= 1'b0;
    end else begin
      commit_o <= 1'b0;
      err_o    <= 1'b0;
      if (abort_i) begin
        cnt_q <= '0;
      end else if (sel_moved) begin
        cnt_q <= '0;
        err_o <= 1'b1;
      end else if (take) begin
        sh_q <= sh_next;
        if (cnt_q == '0) dest_q <= dest_e'(sel_i);
        if (cnt_q == LAST) begin
          cnt_q    <= '0;
          commit_o <= 1'b1;
          word_o   <= sh_next;
          dest_o   <= dest_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R8
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (cnt_q == '0) && !commit_o);
  // R7
  err_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !commit_o && (cnt_q == '0));
  // R4
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n_i && !abort_i && !sel_moved) |=> $stable(cnt_q));
endmodule

// File: rtl/sw_reg_bank.sv
module sw_reg_bank
  import serial_wr_pkg::*;
#(
  parameter int unsigned W = WORD_W,
  parameter int unsigned N = NUM_DEST
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         commit_i,
  input  logic [W-1:0] word_i,
  input  dest_e        dest_i,
  input  logic         conv_done_i,
  input  logic         ready_clr_i,
  output logic [W-1:0] bank_o [N],
  output logic         wr_stb_o,
  output dest_e        wr_dest_o,
  output logic         ready_o
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_o[g] <= '0;
      else if (commit_i && (int'(dest_i) == g)) bank_o[g] <= word_i;
    end

    // R3
    reg_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bank_o[g]) |-> wr_stb_o && (int'(wr_dest_o) == g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb_o  <= 1'b0;
      wr_dest_o <= DEST_CTRL;
      ready_o   <= 1'b0;
    end else begin
      wr_stb_o  <= commit_i;
      if (commit_i) wr_dest_o <= dest_i;
      if (conv_done_i) ready_o <= 1'b1;
      else if (ready_clr_i) ready_o <= 1'b0;
    end
  end

  // R6
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);
  // R9
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_done_i && !ready_clr_i) |=> $stable(ready_o));
endmodule

// File: rtl/serial_write_rx.sv
module serial_write_rx
  import serial_wr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              frame_n_i,
  input  logic              sdata_i,
  input  logic              dest_sel_i,
  input  logic              abort_i,
  input  logic              conv_done_i,
  input  logic              ready_clr_i,
  output logic [WORD_W-1:0] ctrl_word_o,
  output logic [WORD_W-1:0] cal_word_o,
  output logic              wr_stb_o,
  output logic              wr_dest_o,
  output logic              proto_err_o,
  output logic              ready_o
);
  // bit order: {sclk, frame_n, data, sel}
  localparam int unsigned NSYNC = 4;

  logic [NSYNC-1:0]  raw_in, syn;
  logic              sample_stb;
  logic              commit;
  logic [WORD_W-1:0] word;
  dest_e             cdest;
  dest_e             wdest;
  logic [WORD_W-1:0] bank [NUM_DEST];

  assign raw_in = {sclk_i, frame_n_i, sdata_i, dest_sel_i};

  sw_sync #(.W(NSYNC), .STAGES(2), .RST_VAL(4'b0100)) i_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(syn)
  );

  sw_edge i_edge (
    .clk(clk), .rst_n(rst_n), .level_i(syn[3]), .rise_o(sample_stb)
  );

  sw_shift_core #(.W(WORD_W)) i_core (
    .clk(clk), .rst_n(rst_n), .sample_stb_i(sample_stb),
    .frame_n_i(syn[2]), .data_i(syn[1]), .sel_i(syn[0]),
    .abort_i(abort_i), .commit_o(commit), .word_o(word),
    .dest_o(cdest), .err_o(proto_err_o)
  );

  sw_reg_bank #(.W(WORD_W), .N(NUM_DEST)) i_bank (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .word_i(word),
    .dest_i(cdest), .conv_done_i(conv_done_i), .ready_clr_i(ready_clr_i),
    .bank_o(bank), .wr_stb_o(wr_stb_o), .wr_dest_o(wdest), .ready_o(ready_o)
  );

  assign ctrl_word_o = bank[DEST_CTRL];
  assign cal_word_o  = bank[DEST_CAL];
  assign wr_dest_o   = wdest;

  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |=> !proto_err_o);
endmodule

// File: tb/test_serial_write_rx.sv
module test_serial_write_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, frame_n = 1'b1, sdata = 1'b0, sel = 1'b0;
  logic abort = 1'b0, conv_done = 1'b0, rd_clr = 1'b0;
  logic [23:0] ctrl_w, cal_w;
  logic wr_stb, wr_dest, perr, rdy;

  int checks = 0, errors = 0;
  int stb_cnt = 0, err_cnt = 0, wide_stb = 0;
  logic last_dest = 1'b0;
  logic stb_prev = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_write_rx i_serial_write_rx (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .frame_n_i(frame_n),
    .sdata_i(sdata), .dest_sel_i(sel), .abort_i(abort),
    .conv_done_i(conv_done), .ready_clr_i(rd_clr),
    .ctrl_word_o(ctrl_w), .cal_word_o(cal_w), .wr_stb_o(wr_stb),
    .wr_dest_o(wr_dest), .proto_err_o(perr), .ready_o(rdy)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin stb_cnt++; last_dest = wr_dest; end
      if (wr_stb && stb_prev) wide_stb++;
      if (perr) err_cnt++;
      stb_prev = wr_stb;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    sdata = b; wait_clk(8);
    sclk = 1'b1; wait_clk(8);
    sclk = 1'b0;
  endtask

  task automatic send_bits(input logic [23:0] w, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) sbit(w[i]);
  endtask

  task automatic send_word(input logic [23:0] w, input logic d);
    sel = d; wait_clk(4);
    frame_n = 1'b0; wait_clk(4);
    send_bits(w, 23, 0);
    frame_n = 1'b1; wait_clk(10);
  endtask

  task automatic t_reset;
    check(ctrl_w == 0 && cal_w == 0, "R1 regs", {ctrl_w[15:0], cal_w[15:0]}, 0);
    check({wr_stb, wr_dest, perr, rdy} == 4'b0, "R1 flags", {wr_stb, wr_dest, perr, rdy}, 0);
  endtask

  task automatic t_basic;
    int s0 = stb_cnt;
    send_word(24'hA1B2C3, 1'b0);
    check(ctrl_w == 24'hA1B2C3, "R2 ctrl word", ctrl_w, 24'hA1B2C3);
    check(cal_w == 0, "R3 cal untouched", cal_w, 0);
    check(stb_cnt == s0 + 1 && last_dest == 1'b0, "R6 strobe ctrl", stb_cnt - s0, 1);
    send_word(24'h80_0001, 1'b1);
    check(cal_w == 24'h800001, "R3 cal word", cal_w, 24'h800001);
    check(ctrl_w == 24'hA1B2C3, "R3 ctrl untouched", ctrl_w, 24'hA1B2C3);
    check(last_dest == 1'b1, "R6 dest cal", last_dest, 1);
    check(wide_stb == 0, "R6 pulse width", wide_stb, 0);
  endtask

  task automatic t_frame_high;
    int s0 = stb_cnt;
    sdata = 1'b1;
    for (int i = 0; i < 30; i++) sbit(1'b1);
    wait_clk(10);
    check(stb_cnt == s0, "R4 no commit outside frame", stb_cnt - s0, 0);
    send_word(24'h3C5A96, 1'b0);
    check(ctrl_w == 24'h3C5A96, "R4 word after idle edges", ctrl_w, 24'h3C5A96);
  endtask

  task automatic t_pause;
    int s0 = stb_cnt;
    sel = 1'b1; wait_clk(4);
    frame_n = 1'b0; wait_clk(4);
    send_bits(24'hE70F31, 23, 12);
    frame_n = 1'b1; wait_clk(4);
    for (int i = 0; i < 5; i++) sbit(i[0]);
    wait_clk(10);
    check(stb_cnt == s0, "R6 partial not committed", stb_cnt - s0, 0);
    frame_n = 1'b0; wait_clk(4);
    send_bits(24'hE70F31, 11, 0);
    frame_n = 1'b1; wait_clk(10);
    check(cal_w == 24'hE70F31, "R5 paused word", cal_w, 24'hE70F31);
  endtask

  task automatic t_sel_change;
    int e0 = err_cnt;
    int s0 = stb_cnt;
    sel = 1'b0; wait_clk(4);
    frame_n = 1'b0; wait_clk(4);
    send_bits(24'hFFFFFF, 23, 19);
    sel = 1'b1; wait_clk(10);
    check(err_cnt == e0 + 1, "R7 error pulse", err_cnt - e0, 1);
    send_bits(24'h123456, 23, 0);
    frame_n = 1'b1; wait_clk(10);
    check(cal_w == 24'h123456, "R7 fresh word", cal_w, 24'h123456);
    check(stb_cnt == s0 + 1 && ctrl_w == 24'h3C5A96, "R7 dropped word", ctrl_w, 24'h3C5A96);
  endtask

  task automatic t_abort;
    sel = 1'b0; wait_clk(4);
    frame_n = 1'b0; wait_clk(4);
    send_bits(24'hFFFFFF, 23, 14);
    abort = 1'b1; wait_clk(1); abort = 1'b0; wait_clk(2);
    send_bits(24'h0F00F0, 23, 0);
    frame_n = 1'b1; wait_clk(10);
    check(ctrl_w == 24'h0F00F0, "R8 abort then word", ctrl_w, 24'h0F00F0);
  endtask

  task automatic t_ready;
    conv_done = 1'b1; wait_clk(1); conv_done = 1'b0; wait_clk(1);
    check(rdy == 1'b1, "R9 set", rdy, 1);
    send_word(24'h55AA55, 1'b1);
    check(rdy == 1'b1, "R9 write leaves flag", rdy, 1);
    rd_clr = 1'b1; wait_clk(1); rd_clr = 1'b0; wait_clk(1);
    check(rdy == 1'b0, "R9 clear", rdy, 0);
    conv_done = 1'b1; rd_clr = 1'b1; wait_clk(1);
    conv_done = 1'b0; rd_clr = 1'b0; wait_clk(1);
    check(rdy == 1'b1, "R9 set priority", rdy, 1);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_basic();
    t_frame_high();
    t_pause();
    t_sel_change();
    t_abort();
    t_ready();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule